// File: doc/BRIEF.md
# Stack Frame Save and Restore Sequencer

This block moves processor context between a register set and a byte-wide memory port. The stack grows downward. On a request it walks a fixed frame one byte per clock. A subroutine call saves a two-byte return address. A software interrupt or a wait-for-interrupt saves a nine-byte full context. The two return kinds read those frames back in the opposite order. When a sequence ends, the block reports the new stack pointer and, for returns, the restored register values.

The memory port gives read data in the same cycle as the read strobe. A surrounding core supplies the register values and the current stack pointer on the request cycle. It takes the results once `done` pulses. For a wait-for-interrupt request, the block parks after the frame is stored and holds until an interrupt input arrives.

Top module: `stack_seq_top`

## Requirements
- R1: Request kind 0 (call) writes the return high byte at SP and the return low byte at SP-1, then reports SP-2 on `sp_out`.
- R2: Request kind 1 (subroutine return) reads the low byte at SP+1 and the high byte at SP+2, presents them on `ret_out`, and reports SP+2.
- R3: Request kind 2 (software interrupt) writes nine bytes at descending addresses SP down to SP-8: return high, return low, Y low, Y high, X low, X high, A, B, condition code. It then reports SP-9.
- R4: Request kind 4 (interrupt return) reads SP+1 through SP+9 in ascending order as condition code, B, A, X high, X low, Y high, Y low, return low, return high. It drives all restored outputs from those bytes and reports SP+9.
- R5: Request kind 3 (wait) stores the same frame as R3 and reports SP-9. `waiting` and `busy` then stay high with no memory access until `irq_in` is sampled high. After that, `done` pulses and `waiting` drops.
- R6: If a request is accepted at a clock edge, its k-th byte access (k from 0) appears in cycle k+1 after that edge. `done` is high for exactly the one cycle after the final access, and `busy` is low in that cycle.
- R7: At most one memory access occurs per cycle. `mem_we` and `mem_re` are never high together.
- R8: `busy` is high from the cycle after acceptance until the sequence ends. A `req_valid` seen while busy starts nothing and does not change the frame or the reported SP.
- R9: Request kind codes 5, 6 and 7 are ignored: no access takes place and `busy` stays low.
- R10: Address and SP arithmetic wraps modulo 2^16. A call at SP=0x0000 writes 0x0000 and 0xFFFF and reports 0xFFFE. A subroutine return at 0xFFFE reads 0xFFFF and 0x0000 and reports 0x0000.
- R11: After reset, `busy`, `done`, `waiting`, `mem_we` and `mem_re` are low and `sp_out` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_kind | input | 3 | 0 call, 1 subroutine return, 2 software interrupt, 3 wait, 4 interrupt return |
| sp_in | input | 16 | Stack pointer at request time |
| ret_in | input | 16 | Return address to save |
| ccr_in | input | 8 | Condition code to save |
| acc_a_in | input | 8 | Accumulator A to save |
| acc_b_in | input | 8 | Accumulator B to save |
| idx_x_in | input | 16 | Index X to save |
| idx_y_in | input | 16 | Index Y to save |
| irq_in | input | 1 | Interrupt seen, releases the wait hold |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_re` |
| mem_addr | output | 16 | Byte address of the current access |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| waiting | output | 1 | Frame stored, waiting for interrupt |
| sp_out | output | 16 | Stack pointer after the last sequence |
| ret_out | output | 16 | Restored return address |
| ccr_out | output | 8 | Restored condition code |
| acc_a_out | output | 8 | Restored accumulator A |
| acc_b_out | output | 8 | Restored accumulator B |
| idx_x_out | output | 16 | Restored index X |
| idx_y_out | output | 16 | Restored index Y |

## Verification
The assertions check properties that hold on every cycle. Read and write strobes never overlap. Consecutive writes step the address down by one and consecutive reads step it up by one, across the 16-bit wrap. Any access implies `busy`. The wait hold shows no access. `done` is a single pulse that only occurs when idle. Only the bench scenarios can show the byte layout of each frame, the exact completion cycle, the restored register values and the reported SP. The same holds for requests ignored mid-sequence or with reserved codes, because each of these needs a known stack image and a known request history.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int BYTE_W     = 8;
  localparam int RET_BYTES  = 2;
  localparam int ADDR_W     = RET_BYTES * BYTE_W;
  localparam int FULL_BYTES = 9;
  localparam int STEP_W     = $clog2(FULL_BYTES + 1);
  localparam int FRAME_W    = FULL_BYTES * BYTE_W;

  // slot numbers follow the save order, slot 0 stored at the original SP
  localparam int SLOT_RH = 0;
  localparam int SLOT_RL = 1;
  localparam int SLOT_YL = 2;
  localparam int SLOT_YH = 3;
  localparam int SLOT_XL = 4;
  localparam int SLOT_XH = 5;
  localparam int SLOT_A  = 6;
  localparam int SLOT_B  = 7;
  localparam int SLOT_CC = 8;

  typedef enum logic [2:0] {
    K_CALL = 3'd0,
    K_RSUB = 3'd1,
    K_SWI  = 3'd2,
    K_WAIT = 3'd3,
    K_RINT = 3'd4
  } req_kind_e;
endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic              irq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [STEP_W-1:0] slot_idx,
  output logic              load_frame,
  output logic              busy,
  output logic              done,
  output logic              waiting,
  output logic [ADDR_W-1:0] sp_out
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} state_e;

  state_e            state;
  logic [STEP_W-1:0] step, len;
  logic              rd_mode, wait_mode;
  logic [ADDR_W-1:0] sp_base;

  logic              kind_ok, kind_rd, kind_wait, accept, last;
  logic [STEP_W-1:0] kind_len;
  logic [ADDR_W-1:0] sp_final;

  always_comb begin
    kind_ok   = 1'b1;
    kind_rd   = 1'b0;
    kind_wait = 1'b0;
    kind_len  = STEP_W'(FULL_BYTES);
    case (req_kind)
      K_CALL: kind_len = STEP_W'(RET_BYTES);
      K_RSUB: begin kind_len = STEP_W'(RET_BYTES); kind_rd = 1'b1; end
      K_SWI:  kind_len = STEP_W'(FULL_BYTES);
      K_WAIT: kind_wait = 1'b1;
      K_RINT: kind_rd = 1'b1;
      default: kind_ok = 1'b0;
    endcase
  end

  assign accept     = (state == S_IDLE) && req_valid && kind_ok;
  assign load_frame = accept && !kind_rd;
  assign last       = (step == len - STEP_W'(1));
  assign sp_final   = rd_mode ? sp_base + ADDR_W'(len) : sp_base - ADDR_W'(len);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step      <= '0;
      len       <= '0;
      rd_mode   <= 1'b0;
      wait_mode <= 1'b0;
      sp_base   <= '0;
      mem_addr  <= '0;
      done      <= 1'b0;
      sp_out    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state     <= S_RUN;
          step      <= '0;
          len       <= kind_len;
          rd_mode   <= kind_rd;
          wait_mode <= kind_wait;
          sp_base   <= sp_in;
          mem_addr  <= kind_rd ? sp_in + ADDR_W'(1) : sp_in;
        end
        S_RUN: if (last) begin
          sp_out <= sp_final;
          if (wait_mode) state <= S_HOLD;
          else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end else begin
          step     <= step + STEP_W'(1);
          mem_addr <= rd_mode ? mem_addr + ADDR_W'(1) : mem_addr - ADDR_W'(1);
        end
        S_HOLD: if (irq_in) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_we   = (state == S_RUN) && !rd_mode;
  assign mem_re   = (state == S_RUN) && rd_mode;
  assign slot_idx = rd_mode ? (len - STEP_W'(1) - step) : step;
  assign busy     = (state != S_IDLE);
  assign waiting  = (state == S_HOLD);
endmodule

// File: rtl/stack_frame_buf.sv
module stack_frame_buf
  import stack_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               capture,
  input  logic [STEP_W-1:0]  idx,
  input  logic [BYTE_W-1:0]  rdata,
  input  logic [FRAME_W-1:0] load_bytes,
  output logic [FRAME_W-1:0] slots,
  output logic [BYTE_W-1:0]  wdata
);
  for (genvar g = 0; g < FULL_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slots[g*BYTE_W +: BYTE_W] <= '0;
      else if (load)
        slots[g*BYTE_W +: BYTE_W] <= load_bytes[g*BYTE_W +: BYTE_W];
      else if (capture && idx == STEP_W'(g))
        slots[g*BYTE_W +: BYTE_W] <= rdata;
    end
  end

  always_comb begin
    wdata = '0;
    for (int i = 0; i < FULL_BYTES; i++)
      if (idx == STEP_W'(i)) wdata = slots[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/stack_seq_top.sv
module stack_seq_top
  import stack_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] ret_in,
  input  logic [BYTE_W-1:0] ccr_in,
  input  logic [BYTE_W-1:0] acc_a_in,
  input  logic [BYTE_W-1:0] acc_b_in,
  input  logic [ADDR_W-1:0] idx_x_in,
  input  logic [ADDR_W-1:0] idx_y_in,
  input  logic              irq_in,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              waiting,
  output logic [ADDR_W-1:0] sp_out,
  output logic [ADDR_W-1:0] ret_out,
  output logic [BYTE_W-1:0] ccr_out,
  output logic [BYTE_W-1:0] acc_a_out,
  output logic [BYTE_W-1:0] acc_b_out,
  output logic [ADDR_W-1:0] idx_x_out,
  output logic [ADDR_W-1:0] idx_y_out
);
  logic [STEP_W-1:0]  slot_idx;
  logic               load_frame;
  logic [FRAME_W-1:0] load_bytes, slots;

  assign load_bytes = {ccr_in, acc_b_in, acc_a_in,
                       idx_x_in[ADDR_W-1:BYTE_W], idx_x_in[BYTE_W-1:0],
                       idx_y_in[ADDR_W-1:BYTE_W], idx_y_in[BYTE_W-1:0],
                       ret_in[BYTE_W-1:0], ret_in[ADDR_W-1:BYTE_W]};

  stack_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .sp_in      (sp_in),
    .irq_in     (irq_in),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .slot_idx   (slot_idx),
    .load_frame (load_frame),
    .busy       (busy),
    .done       (done),
    .waiting    (waiting),
    .sp_out     (sp_out)
  );

  stack_frame_buf u_buf (
    .clk        (clk),
    .rst        (rst),
    .load       (load_frame),
    .capture    (mem_re),
    .idx        (slot_idx),
    .rdata      (mem_rdata),
    .load_bytes (load_bytes),
    .slots      (slots),
    .wdata      (mem_wdata)
  );

  assign ret_out   = {slots[SLOT_RH*BYTE_W +: BYTE_W], slots[SLOT_RL*BYTE_W +: BYTE_W]};
  assign ccr_out   = slots[SLOT_CC*BYTE_W +: BYTE_W];
  assign acc_a_out = slots[SLOT_A*BYTE_W +: BYTE_W];
  assign acc_b_out = slots[SLOT_B*BYTE_W +: BYTE_W];
  assign idx_x_out = {slots[SLOT_XH*BYTE_W +: BYTE_W], slots[SLOT_XL*BYTE_W +: BYTE_W]};
  assign idx_y_out = {slots[SLOT_YH*BYTE_W +: BYTE_W], slots[SLOT_YL*BYTE_W +: BYTE_W]};
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk
  import stack_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              busy,
  input logic              done,
  input logic              waiting
);
  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R7

  AST_WRITE_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_addr == ADDR_W'($past(mem_addr) - ADDR_W'(1))); // R3

  AST_READ_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(mem_re)) |-> mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1))); // R4

  AST_ACCESS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> busy); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !waiting)); // R6

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    waiting |-> (busy && !mem_we && !mem_re)); // R5
endmodule

bind stack_seq_top stack_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .busy     (busy),
  .done     (done),
  .waiting  (waiting)
);

// File: tb/stack_seq_top_test.sv
module stack_seq_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [15:0] sp_in = '0, ret_in = '0, idx_x_in = '0, idx_y_in = '0;
  logic [7:0]  ccr_in = '0, acc_a_in = '0, acc_b_in = '0;
  logic        irq_in = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr, sp_out, ret_out, idx_x_out, idx_y_out;
  logic        mem_we, mem_re, busy, done, waiting;
  logic [7:0]  mem_wdata, ccr_out, acc_a_out, acc_b_out;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic [7:0]  data;
    string       tag;
  } acc_t;
  acc_t exp_q[$];
  logic [7:0] mem [logic [15:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_seq_top uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .sp_in(sp_in), .ret_in(ret_in), .ccr_in(ccr_in), .acc_a_in(acc_a_in),
    .acc_b_in(acc_b_in), .idx_x_in(idx_x_in), .idx_y_in(idx_y_in),
    .irq_in(irq_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .busy(busy),
    .done(done), .waiting(waiting), .sp_out(sp_out), .ret_out(ret_out),
    .ccr_out(ccr_out), .acc_a_out(acc_a_out), .acc_b_out(acc_b_out),
    .idx_x_out(idx_x_out), .idx_y_out(idx_y_out)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected accesses, models memory
  always @(negedge clk) begin
    acc_t e;
    if (!rst && (mem_we || mem_re)) begin
      check(!(mem_we && mem_re), "R7", "both strobes", {mem_we, mem_re}, 2'b00);
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected access addr", mem_addr, 32'hFFFF_FFFF);
      end else begin
        e = exp_q.pop_front();
        check(mem_addr == e.addr, e.tag, "access addr", mem_addr, e.addr);
        check(mem_we == e.we, e.tag, "access write", mem_we, e.we);
        if (e.we) check(mem_wdata == e.data, e.tag, "write data", mem_wdata, e.data);
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    end
  end

  task automatic push_w(input logic [15:0] a, input logic [7:0] d, input string tag);
    acc_t e;
    e.addr = a; e.we = 1'b1; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_reads(input logic [15:0] sp, input int n, input string tag);
    acc_t e;
    for (int k = 0; k < n; k++) begin
      e.addr = sp + 16'(k + 1); e.we = 1'b0; e.data = '0; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  // full frame layout per R3: descending from SP
  task automatic push_full(input logic [15:0] sp, input logic [15:0] r, input logic [7:0] cc,
                           input logic [7:0] a, input logic [7:0] b,
                           input logic [15:0] x, input logic [15:0] y, input string tag);
    push_w(sp,          r[15:8], tag);
    push_w(sp - 16'd1,  r[7:0],  tag);
    push_w(sp - 16'd2,  y[7:0],  tag);
    push_w(sp - 16'd3,  y[15:8], tag);
    push_w(sp - 16'd4,  x[7:0],  tag);
    push_w(sp - 16'd5,  x[15:8], tag);
    push_w(sp - 16'd6,  a,       tag);
    push_w(sp - 16'd7,  b,       tag);
    push_w(sp - 16'd8,  cc,      tag);
  endtask

  // drives one request cycle; returns at the negedge of the first access cycle
  task automatic start_req(input logic [2:0] k, input logic [15:0] sp, input logic [15:0] r,
                           input logic [7:0] cc, input logic [7:0] a, input logic [7:0] b,
                           input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    req_kind = k; sp_in = sp; ret_in = r; ccr_in = cc;
    acc_a_in = a; acc_b_in = b; idx_x_in = x; idx_y_in = y;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // R6: done exactly n cycles later, single pulse
  task automatic finish_seq(input int n, input logic [15:0] exp_sp, input string tag);
    repeat (n) @(negedge clk);
    check(done === 1'b1, "R6", "done at completion", done, 1);
    check(busy === 1'b0, "R6", "busy in done cycle", busy, 0);
    check(sp_out == exp_sp, tag, "sp_out", sp_out, exp_sp);
    @(negedge clk);
    check(done === 1'b0, "R6", "done single pulse", done, 0);
    check(exp_q.size() == 0, tag, "pending accesses", exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check(busy === 1'b0 && done === 1'b0 && waiting === 1'b0, "R11", "status after reset",
          {busy, done, waiting}, 0);
    check(mem_we === 1'b0 && mem_re === 1'b0, "R11", "strobes after reset", {mem_we, mem_re}, 0);
    check(sp_out === 16'h0000, "R11", "sp_out after reset", sp_out, 0);

    // R1 call
    push_w(16'h1000, 8'hAB, "R1");
    push_w(16'h0FFF, 8'hCD, "R1");
    start_req(3'd0, 16'h1000, 16'hABCD, 8'h00, 8'h00, 8'h00, 16'h0, 16'h0);
    check(busy === 1'b1, "R8", "busy after accept", busy, 1);
    finish_seq(2, 16'h0FFE, "R1");

    // R2 subroutine return from a preloaded image
    mem[16'h4001] = 8'h34;
    mem[16'h4002] = 8'h12;
    push_reads(16'h4000, 2, "R2");
    start_req(3'd1, 16'h4000, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0);
    finish_seq(2, 16'h4002, "R2");
    check(ret_out == 16'h1234, "R2", "restored return", ret_out, 16'h1234);

    // R3 software interrupt
    push_full(16'h2000, 16'h1357, 8'hC4, 8'h11, 8'h22, 16'h3344, 16'h5566, "R3");
    start_req(3'd2, 16'h2000, 16'h1357, 8'hC4, 8'h11, 8'h22, 16'h3344, 16'h5566);
    finish_seq(9, 16'h1FF7, "R3");

    // R4 interrupt return from a different preloaded frame
    mem[16'h2FF8] = 8'h5A; mem[16'h2FF9] = 8'h0B; mem[16'h2FFA] = 8'h0A;
    mem[16'h2FFB] = 8'h71; mem[16'h2FFC] = 8'h72; mem[16'h2FFD] = 8'h81;
    mem[16'h2FFE] = 8'h82; mem[16'h2FFF] = 8'hEF; mem[16'h3000] = 8'hBE;
    push_reads(16'h2FF7, 9, "R4");
    start_req(3'd4, 16'h2FF7, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0);
    finish_seq(9, 16'h3000, "R4");
    check(ccr_out == 8'h5A, "R4", "ccr", ccr_out, 8'h5A);
    check(acc_b_out == 8'h0B && acc_a_out == 8'h0A, "R4", "acc b,a",
          {acc_b_out, acc_a_out}, 16'h0B0A);
    check(idx_x_out == 16'h7172, "R4", "index x", idx_x_out, 16'h7172);
    check(idx_y_out == 16'h8182, "R4", "index y", idx_y_out, 16'h8182);
    check(ret_out == 16'hBEEF, "R4", "return", ret_out, 16'hBEEF);

    // R5 wait for interrupt
    push_full(16'h5000, 16'h2468, 8'h3C, 8'hA1, 8'hB2, 16'hC3D4, 16'hE5F6, "R5");
    start_req(3'd3, 16'h5000, 16'h2468, 8'h3C, 8'hA1, 8'hB2, 16'hC3D4, 16'hE5F6);
    repeat (9) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check(waiting === 1'b1 && busy === 1'b1 && done === 1'b0, "R5", "holding",
            {waiting, busy, done}, 3'b110);
      @(negedge clk);
    end
    check(sp_out == 16'h4FF7, "R5", "sp_out", sp_out, 16'h4FF7);
    irq_in = 1'b1;
    @(negedge clk);
    irq_in = 1'b0;
    check(done === 1'b1 && waiting === 1'b0 && busy === 1'b0, "R5", "release",
          {done, waiting, busy}, 3'b100);
    @(negedge clk);
    check(done === 1'b0, "R6", "done single pulse after wait", done, 0);

    // R8 request while busy is ignored
    push_full(16'h6000, 16'h1111, 8'h01, 8'h02, 8'h03, 16'h0405, 16'h0607, "R8");
    start_req(3'd2, 16'h6000, 16'h1111, 8'h01, 8'h02, 8'h03, 16'h0405, 16'h0607);
    repeat (2) @(negedge clk);
    req_kind = 3'd0; sp_in = 16'h7000; ret_in = 16'hFFFF; req_valid = 1'b1;
    check(busy === 1'b1, "R8", "busy mid sequence", busy, 1);
    @(negedge clk);
    req_valid = 1'b0;
    finish_seq(6, 16'h5FF7, "R8");
    check(busy === 1'b0, "R8", "no queued request", busy, 0);

    // R10 wrap on call and on return
    push_w(16'h0000, 8'h9A, "R10");
    push_w(16'hFFFF, 8'h9B, "R10");
    start_req(3'd0, 16'h0000, 16'h9A9B, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0);
    finish_seq(2, 16'hFFFE, "R10");
    mem[16'hFFFF] = 8'h77;
    mem[16'h0000] = 8'h66;
    push_reads(16'hFFFE, 2, "R10");
    start_req(3'd1, 16'hFFFE, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0);
    finish_seq(2, 16'h0000, "R10");
    check(ret_out == 16'h6677, "R10", "wrapped return", ret_out, 16'h6677);

    // R9 reserved kinds
    for (int k = 5; k < 8; k++) begin
      start_req(3'(k), 16'h8000, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0);
      repeat (2) begin
        check(busy === 1'b0 && mem_we === 1'b0 && mem_re === 1'b0, "R9", "reserved kind idle",
              {busy, mem_we, mem_re}, 0);
        @(negedge clk);
      end
    end
    check(sp_out == 16'h0000, "R9", "sp_out unchanged", sp_out, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule